// File: doc/BRIEF.md
# Logarithmic Gain-Code Bus Interface and Tap Decoder

This block is the digital control front end of a programmable logarithmic gain/attenuator. A processor writes a gain setting over a parallel bus that has an active-low chip select and an active-low write strobe. The block keeps the setting in holding registers and decodes it into two one-hot 16-line switch-select buses, one for a coarse tap string (1.5 dB per tap, 0 to 22.5 dB) and one for a fine tap string (0.1 dB per tap, 0 to 1.5 dB). It also drives a gain/attenuate mode line that both strings follow and a power-down line. Because the coarse and fine dB values add, the magnitude in 0.1 dB units is `coarse_index * 15 + fine_index`. This covers 0 to 24.0 dB, and the mode line places that magnitude on the gain side or the attenuation side of 0 dB.

The parameter `WIDE_BUS` chooses the bus variant. With `WIDE_BUS = 0` the data bus is 8 bits wide and a setting takes two writes, steered by `addr`. With `WIDE_BUS = 1` the data bus is 9 bits wide and one write loads the whole setting. The bus pins are sampled by `clk`. A write is taken on the clock where `wr_n` is seen rising (low on the previous clock, high now) while `cs_n` is low. The outputs change on that same clock edge.

Top module: `loggain_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, before any write, `coarse_sel` and `fine_sel` are both 16'h0001, `gain_mode` is 0 (attenuate) and `pwr_down` is 0.
- R2: A write is taken only on a clock where `wr_n` is high, `wr_n` was low on the previous clock, and `cs_n` is low. Pulses of `wr_n` while `cs_n` is high have no effect, and neither does holding `wr_n` low.
- R3: `coarse_sel` always has exactly one bit set. Its position equals the coarse index, which is setting bits [7:4].
- R4: `fine_sel` always has exactly one bit set. Its position equals the fine index, which is setting bits [3:0].
- R5: `gain_mode` equals the mode bit of the active setting: 1 = gain, 0 = attenuate.
- R6: Narrow variant: a write with `addr` = 0 stores data[7:4] as the coarse index and data[3:0] as the fine index in a holding register. No output changes on that write.
- R7: Narrow variant: a write with `addr` = 1 takes data[0] as the mode bit and data[1] as power-down. On that same edge it applies the held indices, the mode bit and power-down to the outputs together.
- R8: Wide variant: one write loads data[8] as the mode bit, data[7:4] as the coarse index and data[3:0] as the fine index, whatever the value of `addr`. `pwr_down` stays 0.
- R9: For every one of the 512 settings, the set bit of `coarse_sel` times 15 plus the set bit of `fine_sel` equals the requested magnitude in 0.1 dB units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; bus pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; the rising edge takes data |
| addr | input | 1 | Register steering in the narrow variant; ignored in the wide variant |
| data | input | DATA_W (8 narrow, 9 wide) | Write data |
| coarse_sel | output | 16 | One-hot coarse tap select |
| fine_sel | output | 16 | One-hot fine tap select |
| gain_mode | output | 1 | 1 = gain, 0 = attenuate |
| pwr_down | output | 1 | Power-down request (narrow variant only) |

## Verification
The bench sweeps all 512 settings through both variants. It decodes the two select buses back to indices and checks the summed magnitude, so a swapped nibble or a weight other than 15 shows up as a wrong dB value. After every register-0 write it checks that nothing moved, which catches a design that applies the first write on its own and briefly shows half a gain. Strobes sent with chip select high, and a strobe held low, must leave the outputs alone; a design that takes data on the falling edge or ignores chip select fails these checks. Power-down is toggled through the second write and must never appear on the wide variant.

// File: rtl/loggain_pkg.sv
package loggain_pkg;

    localparam int IDX_W      = 4;
    localparam int TAPS       = 1 << IDX_W;
    localparam int FINE_PER_C = 15;
    localparam int SET_W      = 2 * IDX_W + 1;

    typedef struct packed {
        logic             gain;
        logic [IDX_W-1:0] coarse;
        logic [IDX_W-1:0] fine;
    } gain_set_t;

    localparam gain_set_t SET_RESET = '{gain: 1'b0, coarse: '0, fine: '0};

    function automatic int unsigned set_magnitude(input gain_set_t s);
        return int'(s.coarse) * FINE_PER_C + int'(s.fine);
    endfunction

endpackage

// File: rtl/loggain_strobe.sv
module loggain_strobe (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_n,
    output logic take
);
    logic wr_prev;

    always_ff @(posedge clk) begin
        if (rst) wr_prev <= 1'b1;
        else     wr_prev <= wr_n;
    end

    assign take = wr_n & ~wr_prev & ~cs_n;
endmodule

// File: rtl/loggain_hold.sv
module loggain_hold
    import loggain_pkg::*;
#(
    parameter bit WIDE_BUS = 1'b0,
    parameter int DATA_W   = WIDE_BUS ? SET_W : 2 * IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              addr,
    input  logic [DATA_W-1:0] data,
    output gain_set_t         active,
    output logic              pd
);
    generate
        if (WIDE_BUS) begin : g_wide
            logic unused_addr;
            assign unused_addr = addr;
            assign pd = 1'b0;
            always_ff @(posedge clk) begin
                if (rst)       active <= SET_RESET;
                else if (take) active <= gain_set_t'(data[SET_W-1:0]);
            end
        end else begin : g_narrow
            logic [IDX_W-1:0] stage_c;
            logic [IDX_W-1:0] stage_f;
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_c <= '0;
                    stage_f <= '0;
                    active  <= SET_RESET;
                    pd      <= 1'b0;
                end else if (take) begin
                    if (!addr) begin
                        stage_c <= data[2*IDX_W-1:IDX_W];
                        stage_f <= data[IDX_W-1:0];
                    end else begin
                        active.coarse <= stage_c;
                        active.fine   <= stage_f;
                        active.gain   <= data[0];
                        pd            <= data[1];
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/loggain_tap_dec.sv
module loggain_tap_dec
    import loggain_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [TAPS-1:0]  sel
);
    generate
        for (genvar t = 0; t < TAPS; t++) begin : g_line
            assign sel[t] = (idx == IDX_W'(t));
        end
    endgenerate
endmodule

// File: rtl/loggain_ctrl.sv
module loggain_ctrl
    import loggain_pkg::*;
#(
    parameter bit WIDE_BUS = 1'b0,
    parameter int DATA_W   = WIDE_BUS ? SET_W : 2 * IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic              addr,
    input  logic [DATA_W-1:0] data,
    output logic [TAPS-1:0]   coarse_sel,
    output logic [TAPS-1:0]   fine_sel,
    output logic              gain_mode,
    output logic              pwr_down
);
    logic      take;
    gain_set_t active;

    loggain_strobe u_strobe (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .wr_n (wr_n),
        .take (take)
    );

    loggain_hold #(.WIDE_BUS(WIDE_BUS), .DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .addr   (addr),
        .data   (data),
        .active (active),
        .pd     (pwr_down)
    );

    loggain_tap_dec u_coarse_dec (.idx(active.coarse), .sel(coarse_sel));
    loggain_tap_dec u_fine_dec   (.idx(active.fine),   .sel(fine_sel));

    assign gain_mode = active.gain;
endmodule

// File: rtl/loggain_ctrl_chk.sv
module loggain_ctrl_chk #(
    parameter bit WIDE_BUS = 1'b0,
    parameter int DATA_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              wr_n,
    input logic              addr,
    input logic [DATA_W-1:0] data,
    input logic [15:0]       coarse_sel,
    input logic [15:0]       fine_sel,
    input logic              gain_mode,
    input logic              pwr_down
);
    // R2 R6
    quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !($rose(wr_n) && !cs_n && (WIDE_BUS || addr))
        |=> $stable({coarse_sel, fine_sel, gain_mode, pwr_down}));

    // R3
    coarse_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(coarse_sel) == 1);

    // R4
    fine_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(fine_sel) == 1);

    generate
        if (WIDE_BUS) begin : g_wide
            // R8
            wide_load_chk: assert property (@(posedge clk) disable iff (rst)
                ($rose(wr_n) && !cs_n)
                |=> (gain_mode == $past(data[8])) &&
                    (coarse_sel == (16'h1 << $past(data[7:4]))));
            // R8
            wide_no_pd_chk: assert property (@(posedge clk) disable iff (rst)
                !pwr_down);
        end else begin : g_narrow
            logic unused_hi;
            assign unused_hi = ^data[DATA_W-1:2];
            // R7
            narrow_commit_chk: assert property (@(posedge clk) disable iff (rst)
                ($rose(wr_n) && !cs_n && addr)
                |=> (pwr_down == $past(data[1])) && (gain_mode == $past(data[0])));
        end
    endgenerate
endmodule

bind loggain_ctrl loggain_ctrl_chk #(.WIDE_BUS(WIDE_BUS), .DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .wr_n       (wr_n),
    .addr       (addr),
    .data       (data),
    .coarse_sel (coarse_sel),
    .fine_sel   (fine_sel),
    .gain_mode  (gain_mode),
    .pwr_down   (pwr_down)
);

// File: tb/loggain_ctrl_tb_top.sv
`timescale 1ns/1ps
module loggain_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_nar = 1'b1;
    logic       cs_wid = 1'b1;
    logic       wr_n = 1'b1;
    logic       addr = 1'b0;
    logic [7:0] d_nar = '0;
    logic [8:0] d_wid = '0;

    logic [15:0] nc_sel, nf_sel, wc_sel, wf_sel;
    logic        n_gain, n_pd, w_gain, w_pd;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    loggain_ctrl #(.WIDE_BUS(1'b0)) dut_i (
        .clk(clk), .rst(rst), .cs_n(cs_nar), .wr_n(wr_n), .addr(addr), .data(d_nar),
        .coarse_sel(nc_sel), .fine_sel(nf_sel), .gain_mode(n_gain), .pwr_down(n_pd));

    loggain_ctrl #(.WIDE_BUS(1'b1)) dut_wide_i (
        .clk(clk), .rst(rst), .cs_n(cs_wid), .wr_n(wr_n), .addr(addr), .data(d_wid),
        .coarse_sel(wc_sel), .fine_sel(wf_sel), .gain_mode(w_gain), .pwr_down(w_pd));

    // behavioural reference: integers updated on each rising edge
    int m_nc, m_nf, m_ng, m_npd, m_hc, m_hf;
    int m_wc, m_wf, m_wg;
    bit last_wr;

    always @(posedge clk) begin
        if (rst) begin
            m_nc = 0; m_nf = 0; m_ng = 0; m_npd = 0; m_hc = 0; m_hf = 0;
            m_wc = 0; m_wf = 0; m_wg = 0;
            last_wr = 1'b1;
        end else begin
            if (wr_n && !last_wr) begin
                if (!cs_nar) begin
                    if (!addr) begin
                        m_hc = int'(d_nar) / 16;
                        m_hf = int'(d_nar) % 16;
                    end else begin
                        m_nc = m_hc; m_nf = m_hf;
                        m_ng = int'(d_nar[0]); m_npd = int'(d_nar[1]);
                    end
                end
                if (!cs_wid) begin
                    m_wg = int'(d_wid) / 256;
                    m_wc = (int'(d_wid) / 16) % 16;
                    m_wf = int'(d_wid) % 16;
                end
            end
            last_wr = wr_n;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bit_pos(input logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return i;
        return -1;
    endfunction

    // compare both devices with the reference on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(nc_sel === (16'h1 << m_nc), "R3 narrow coarse", int'(nc_sel), 1 << m_nc);
            chk(nf_sel === (16'h1 << m_nf), "R4 narrow fine", int'(nf_sel), 1 << m_nf);
            chk(int'(n_gain) == m_ng && int'(n_pd) == m_npd, "R5 R7 narrow mode/pd",
                int'({n_gain, n_pd}), m_ng * 2 + m_npd);
            chk(wc_sel === (16'h1 << m_wc), "R3 wide coarse", int'(wc_sel), 1 << m_wc);
            chk(wf_sel === (16'h1 << m_wf), "R4 wide fine", int'(wf_sel), 1 << m_wf);
            chk(int'(w_gain) == m_wg && w_pd === 1'b0, "R8 wide mode/pd",
                int'({w_gain, w_pd}), m_wg * 2);
        end
    end

    task automatic bus_write(input bit wide, input bit a, input int d);
        @(negedge clk);
        addr = a;
        if (wide) begin cs_wid = 1'b0; d_wid = 9'(d); end
        else      begin cs_nar = 1'b0; d_nar = 8'(d); end
        wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_nar = 1'b1;
        cs_wid = 1'b1;
    endtask

    task automatic stray_pulse(input int d);
        @(negedge clk);
        d_nar = 8'(d); d_wid = 9'(d); addr = 1'b1;
        wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_setting(input bit wide, input int s);
        logic [15:0] c, f;
        logic        g;
        c = wide ? wc_sel : nc_sel;
        f = wide ? wf_sel : nf_sel;
        g = wide ? w_gain : n_gain;
        chk($countones(c) == 1, "R3 coarse one-hot", $countones(c), 1);
        chk($countones(f) == 1, "R4 fine one-hot", $countones(f), 1);
        chk(bit_pos(c) * 15 + bit_pos(f) == ((s / 16) % 16) * 15 + s % 16,
            "R9 magnitude", bit_pos(c) * 15 + bit_pos(f), ((s / 16) % 16) * 15 + s % 16);
        chk(int'(g) == s / 256, "R5 mode bit", int'(g), s / 256);
    endtask

    initial begin : main
        logic [33:0] snap;
        repeat (3) @(negedge clk);
        // R1 during reset and right after
        chk(nc_sel == 16'h1 && nf_sel == 16'h1 && !n_gain && !n_pd, "R1 reset narrow",
            int'(nc_sel), 1);
        chk(wc_sel == 16'h1 && wf_sel == 16'h1 && !w_gain && !w_pd, "R1 reset wide",
            int'(wc_sel), 1);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(nc_sel == 16'h1 && nf_sel == 16'h1 && !n_gain && !n_pd, "R1 after reset",
            int'(nf_sel), 1);

        // R2: strobe with chip select high has no effect
        stray_pulse(8'hFF);
        chk(nc_sel == 16'h1 && wc_sel == 16'h1 && !n_pd && !w_gain, "R2 stray strobe",
            int'(nc_sel), 1);

        // R2: strobe held low does nothing until it rises
        @(negedge clk);
        cs_wid = 1'b0; d_wid = 9'h1A7; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(wc_sel == 16'h1 && !w_gain, "R2 strobe held low", int'(wc_sel), 1);
        wr_n = 1'b1;
        @(negedge clk);
        cs_wid = 1'b1;
        chk(wc_sel == (16'h1 << 10) && wf_sel == (16'h1 << 7) && w_gain, "R2 R8 rise takes",
            int'(wc_sel), 1 << 10);

        // R7: power-down through the second narrow write
        bus_write(1'b0, 1'b1, 2);
        chk(n_pd === 1'b1, "R7 power-down set", int'(n_pd), 1);
        bus_write(1'b0, 1'b1, 1);
        chk(n_pd === 1'b0 && n_gain === 1'b1, "R7 power-down clear", int'({n_gain, n_pd}), 2);

        // full sweep of both variants
        for (int s = 0; s < 512; s++) begin
            snap = {nc_sel, nf_sel, n_gain, n_pd};
            bus_write(1'b0, 1'b0, s % 256);
            chk({nc_sel, nf_sel, n_gain, n_pd} == snap, "R6 first write holds",
                int'(nc_sel), int'(snap[33:18]));
            bus_write(1'b0, 1'b1, s / 256);
            check_setting(1'b0, s);
            bus_write(1'b1, 1'(s % 2), s);
            check_setting(1'b1, s);
            chk(w_pd === 1'b0, "R8 wide no power-down", int'(w_pd), 0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule